// File: doc/BRIEF.md
# Bit-Banged Two-Wire Bus GPIO Port

This block gives software a tiny general-purpose I/O window through which it drives a two-wire serial bus, with a data line and a clock line, purely by toggling bits. A 32-bit state word is split into byte lanes: a sampled-input byte, an output byte and a direction byte, plus one spare byte. Each lane is read or written one byte at a time over a simple I/O port.

Bit 0 of the output and direction bytes controls the data line. Bit 1 of the same bytes controls the clock line. Both lines are open-drain: the port can only pull a line low or release it. External devices and a pull-up decide the level that every agent sees.

The window has no address until a configuration-space sequence places it. A write to one configuration register stores a base. A later write of a fixed key value to a second configuration register maps the four-byte window at that base plus a fixed offset. The window then answers byte reads and writes.

Each write that changes the byte it targets re-evaluates both bus lines. The same write records the level now seen on the data line into bit 0 of the input byte.

Top module: `gpio_i2c_port`

## Requirements
- R1: After reset the state word is all zero, both bus lines are high, and no I/O address hits the window (io_hit low, io_rdata 0x00).
- R2: A read at window byte offset N (0 to 3) returns bits [8N+7:8N] of the state word. Offset 0 is the input byte, offset 1 the output byte, offset 2 the direction byte and offset 3 a spare byte that holds whatever was last written to it.
- R3: A write to offset 0 changes nothing: neither the state word nor the line levels.
- R4: A write to offset 1, 2 or 3 whose data differs from the current byte stores the byte. It sets input bits 7:1 to zero and sets input bit 0 to the data line level resolved at that write, taking in the new drive and the external pull-down of that cycle.
- R5: On such a changing write, the port drives the data line from output bit 0 (state bit 8) when direction bit 0 (state bit 16) is 1. Otherwise it releases the data line high.
- R6: On such a changing write, the port's clock drive takes output bit 1 (state bit 9) only if direction bit 1 (state bit 17) is 1 after the write. Otherwise the clock drive keeps its previous value.
- R7: Each line is a wired-AND. The line is low whenever the port drives it low or the external pull-down input for that line is high.
- R8: A write whose data equals the byte already held at that offset changes nothing. In particular, input bit 0 is not re-sampled.
- R9: A configuration write to register 0x40 latches the low address bits as the base. A later configuration write of 0x11 to register 0x44 maps the window at base + 0x38 and drops any earlier placement. A new base alone does not move the window.
- R10: A configuration write to register 0x44 with any value other than 0x11 leaves the window placement unchanged.
- R11: The window spans exactly four byte addresses. An I/O access outside those four addresses gives io_hit low and io_rdata 0x00, and a write there leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (8) | Configuration register number |
| cfg_wdata | input | CFG_DW (32) | Configuration write data |
| io_wr | input | 1 | I/O byte write strobe |
| io_addr | input | IO_AW (16) | I/O byte address for reads and writes |
| io_wdata | input | 8 | I/O write byte |
| io_hit | output | 1 | io_addr falls inside the mapped window |
| io_rdata | output | 8 | Byte read at io_addr (combinational), 0x00 when no hit |
| sda_ext_low | input | 1 | An external device pulls the data line low |
| scl_ext_low | input | 1 | An external device pulls the clock line low |
| sda_line | output | 1 | Resolved data line level |
| scl_line | output | 1 | Resolved clock line level |

## Verification
The assertions check these rules on every cycle:
- Offset-0 writes and same-value writes leave the state and drives untouched.
- The drives only move on a changing write.
- A changing write zeroes input bits 7:1.
- A rejected key leaves the window placement unchanged.
- An external pull-down always wins on either line.

Some behaviour only the directed scenarios can show. The first is the exact sampled value of input bit 0 under an external pull-down. The second is the clock drive holding through direction changes. The remaining cases are the window moving only once the key follows a new base, and the four-byte boundary on both sides.

// File: rtl/gpio_i2c_pkg.sv
package gpio_i2c_pkg;
   // byte lanes of the state word, in address order
   typedef enum logic [1:0] {
      LANE_IN    = 2'd0,
      LANE_OUT   = 2'd1,
      LANE_DIR   = 2'd2,
      LANE_SPARE = 2'd3
   } lane_e;

   // bit positions inside the output and direction bytes
   localparam int DATA_BIT  = 0;
   localparam int CLOCK_BIT = 1;

   localparam int LANE_W  = 8;
   localparam int N_LANES = 4;
   localparam int WORD_W  = LANE_W * N_LANES;
   localparam int N_LINES = 2;
endpackage

// File: rtl/gpio_i2c_window.sv
module gpio_i2c_window #(
   parameter int               IO_AW    = 16,
   parameter int               CFG_AW   = 8,
   parameter int               CFG_DW   = 32,
   parameter logic [CFG_AW-1:0] BASE_REG = 'h40,
   parameter logic [CFG_AW-1:0] EN_REG   = 'h44,
   parameter logic [CFG_DW-1:0] EN_KEY   = 'h11,
   parameter logic [IO_AW-1:0]  WIN_OFS  = 'h38
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic [IO_AW-1:0]  io_addr,
   output logic              hit,
   output logic [1:0]        lane
);
   import gpio_i2c_pkg::*;

   localparam logic [IO_AW-1:0] SPAN = IO_AW'(N_LANES);

   generate
      if (IO_AW < 8)       begin : g_bad_aw  $error("IO_AW too small");  end
      if (CFG_DW < IO_AW)  begin : g_bad_dw  $error("CFG_DW below IO_AW"); end
   endgenerate

   logic [IO_AW-1:0] base_q;
   logic [IO_AW-1:0] win_q;
   logic             mapped_q;
   logic [IO_AW-1:0] delta;

   wire base_wr = cfg_wr && (cfg_addr == BASE_REG);
   wire en_wr   = cfg_wr && (cfg_addr == EN_REG);
   wire key_ok  = en_wr && (cfg_wdata == EN_KEY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         win_q    <= '0;
         mapped_q <= 1'b0;
      end else begin
         if (base_wr) base_q <= cfg_wdata[IO_AW-1:0];
         if (key_ok) begin
            win_q    <= base_q + WIN_OFS;
            mapped_q <= 1'b1;
         end
      end
   end

   always_comb begin
      delta = io_addr - win_q;
      hit   = mapped_q && (delta < SPAN);
      lane  = delta[1:0];
   end

   // R10
   key_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && cfg_wdata != EN_KEY) |=> ($stable(win_q) && $stable(mapped_q)));
endmodule

// File: rtl/gpio_i2c_regbank.sv
module gpio_i2c_regbank
   import gpio_i2c_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        lane,
   input  logic [LANE_W-1:0] wdata,
   input  logic              sda_ext_low,
   output logic [LANE_W-1:0] rdata,
   output logic              sda_drv,
   output logic              scl_drv
);
   logic [WORD_W-1:0] word_q, word_n;
   logic              sda_n, scl_n;
   logic [LANE_W-1:0] cur;
   logic              fire;

   always_comb begin
      cur  = word_q[int'(lane)*LANE_W +: LANE_W];
      fire = wr_en && (lane != LANE_IN) && (wdata != cur);

      word_n = word_q;
      word_n[int'(lane)*LANE_W +: LANE_W] = wdata;
      word_n[LANE_W-1:0] = '0;
      sda_n = word_n[LANE_DIR*LANE_W + DATA_BIT] ? word_n[LANE_OUT*LANE_W + DATA_BIT] : 1'b1;
      scl_n = word_n[LANE_DIR*LANE_W + CLOCK_BIT] ? word_n[LANE_OUT*LANE_W + CLOCK_BIT] : scl_drv;
      word_n[0] = sda_n & ~sda_ext_low;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q  <= '0;
         sda_drv <= 1'b1;
         scl_drv <= 1'b1;
      end else if (fire) begin
         word_q  <= word_n;
         sda_drv <= sda_n;
         scl_drv <= scl_n;
      end
   end

   assign rdata = cur;

   // R3
   in_lane_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lane == LANE_IN) |=> ($stable(word_q) && $stable(sda_drv) && $stable(scl_drv)));
   // R8
   same_byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata == cur) |=> ($stable(word_q) && $stable(sda_drv) && $stable(scl_drv)));
   // R4
   in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (word_q[LANE_W-1:1] == '0));
   // R6
   drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(sda_drv) && $stable(scl_drv)));
endmodule

// File: rtl/gpio_i2c_pad.sv
module gpio_i2c_pad (
   input  logic clk,
   input  logic rst_n,
   input  logic drv,
   input  logic ext_low,
   output logic line
);
   assign line = drv & ~ext_low;

   // R7
   pull_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_low || !drv) |-> !line);
endmodule

// File: rtl/gpio_i2c_port.sv
module gpio_i2c_port #(
   parameter int               IO_AW    = 16,
   parameter int               CFG_AW   = 8,
   parameter int               CFG_DW   = 32,
   parameter logic [CFG_AW-1:0] BASE_REG = 'h40,
   parameter logic [CFG_AW-1:0] EN_REG   = 'h44,
   parameter logic [CFG_DW-1:0] EN_KEY   = 'h11,
   parameter logic [IO_AW-1:0]  WIN_OFS  = 'h38
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic              io_wr,
   input  logic [IO_AW-1:0]  io_addr,
   input  logic [7:0]        io_wdata,
   output logic              io_hit,
   output logic [7:0]        io_rdata,
   input  logic              sda_ext_low,
   input  logic              scl_ext_low,
   output logic              sda_line,
   output logic              scl_line
);
   import gpio_i2c_pkg::*;

   logic [1:0]         lane;
   logic [LANE_W-1:0]  bank_rdata;
   logic [N_LINES-1:0] drv, ext, lines;

   gpio_i2c_window #(
      .IO_AW(IO_AW), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW),
      .BASE_REG(BASE_REG), .EN_REG(EN_REG), .EN_KEY(EN_KEY), .WIN_OFS(WIN_OFS)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .io_addr(io_addr), .hit(io_hit), .lane(lane)
   );

   gpio_i2c_regbank u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(io_wr && io_hit), .lane(lane),
      .wdata(io_wdata), .sda_ext_low(sda_ext_low), .rdata(bank_rdata),
      .sda_drv(drv[DATA_BIT]), .scl_drv(drv[CLOCK_BIT])
   );

   assign ext[DATA_BIT]  = sda_ext_low;
   assign ext[CLOCK_BIT] = scl_ext_low;

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_pad
         gpio_i2c_pad u_pad (
            .clk(clk), .rst_n(rst_n), .drv(drv[i]), .ext_low(ext[i]), .line(lines[i])
         );
      end
   endgenerate

   assign sda_line = lines[DATA_BIT];
   assign scl_line = lines[CLOCK_BIT];
   assign io_rdata = io_hit ? bank_rdata : 8'h00;

   // R11
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_hit) |=> ($stable(drv)));
endmodule

// File: tb/gpio_i2c_port_bench.sv
module gpio_i2c_port_bench;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_hit;
   logic [7:0]  io_rdata;
   logic        sda_ext_low = 1'b0;
   logic        scl_ext_low = 1'b0;
   logic        sda_line, scl_line;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_i2c_port u_gpio_i2c_port (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_hit(io_hit), .io_rdata(io_rdata), .sda_ext_low(sda_ext_low),
      .scl_ext_low(scl_ext_low), .sda_line(sda_line), .scl_line(scl_line)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic h);
      @(negedge clk);
      io_addr = a;
      #1;
      d = io_rdata; h = io_hit;
   endtask

   task automatic t_reset();
      logic [7:0] d; logic h;
      io_read(16'h0038, d, h);
      check("R1 hit after reset", h, 0);
      check("R1 rdata after reset", d, 0);
      check("R1 sda after reset", sda_line, 1);
      check("R1 scl after reset", scl_line, 1);
   endtask

   task automatic t_map();
      logic [7:0] d; logic h;
      cfg_write(8'h40, 32'h0100);
      cfg_write(8'h44, 32'h22);
      io_read(16'h0138, d, h);
      check("R10 bad key leaves unmapped", h, 0);
      cfg_write(8'h44, 32'h11);
      io_read(16'h0138, d, h);
      check("R9 mapped at base+0x38", h, 1);
      check("R1 input byte zero", d, 0);
      io_read(16'h0137, d, h);
      check("R11 below window", h, 0);
      io_read(16'h013C, d, h);
      check("R11 above window", h, 0);
      check("R11 rdata outside", d, 0);
   endtask

   task automatic t_in_ignored();
      logic [7:0] d; logic h;
      io_write(16'h0138, 8'hA5);
      io_read(16'h0138, d, h);
      check("R3 input byte write ignored", d, 0);
      check("R3 sda unchanged", sda_line, 1);
   endtask

   task automatic t_sda();
      logic [7:0] d; logic h;
      io_write(16'h013A, 8'h01);
      check("R5 sda driven low", sda_line, 0);
      io_read(16'h0138, d, h);
      check("R4 input samples low sda", d, 8'h00);
      io_write(16'h0139, 8'h01);
      check("R5 sda driven high", sda_line, 1);
      io_read(16'h0138, d, h);
      check("R4 input samples high sda", d, 8'h01);
      io_read(16'h0139, d, h);
      check("R2 output byte readback", d, 8'h01);
      io_read(16'h013A, d, h);
      check("R2 direction byte readback", d, 8'h01);
   endtask

   task automatic t_scl();
      io_write(16'h0139, 8'h03);
      check("R6 scl not driven without dir", scl_line, 1);
      io_write(16'h0139, 8'h01);
      check("R6 scl holds with dir clear", scl_line, 1);
      io_write(16'h013A, 8'h03);
      check("R6 scl low once dir set", scl_line, 0);
      io_write(16'h013A, 8'h01);
      check("R6 scl keeps low after dir cleared", scl_line, 0);
      io_write(16'h0139, 8'h03);
      check("R6 scl ignores out with dir clear", scl_line, 0);
      io_write(16'h013A, 8'h03);
      check("R6 scl high with dir set", scl_line, 1);
   endtask

   task automatic t_wired();
      logic [7:0] d; logic h;
      sda_ext_low = 1'b1;
      #1;
      check("R7 sda pulled low externally", sda_line, 0);
      io_write(16'h0139, 8'h07);
      io_read(16'h0138, d, h);
      check("R4 input samples external low", d, 8'h00);
      sda_ext_low = 1'b0;
      #1;
      check("R7 sda released", sda_line, 1);
      io_write(16'h0139, 8'h07);
      io_read(16'h0138, d, h);
      check("R8 same write no resample", d, 8'h00);
      io_write(16'h0139, 8'h03);
      io_read(16'h0138, d, h);
      check("R4 changing write resamples", d, 8'h01);
      scl_ext_low = 1'b1;
      #1;
      check("R7 scl pulled low externally", scl_line, 0);
      scl_ext_low = 1'b0;
   endtask

   task automatic t_outside();
      logic [7:0] d; logic h;
      io_write(16'h0137, 8'h00);
      io_write(16'h013C, 8'hFF);
      io_read(16'h0139, d, h);
      check("R11 outside writes no effect", d, 8'h03);
      io_read(16'h013B, d, h);
      check("R11 spare byte untouched", d, 8'h00);
   endtask

   task automatic t_remap();
      logic [7:0] d; logic h;
      cfg_write(8'h40, 32'h0200);
      io_read(16'h0138, d, h);
      check("R9 base alone keeps window", h, 1);
      cfg_write(8'h44, 32'h11);
      io_read(16'h0138, d, h);
      check("R9 old placement dropped", h, 0);
      io_read(16'h0239, d, h);
      check("R9 new placement hit", h, 1);
      check("R9 state kept over remap", d, 8'h03);
      io_write(16'h023B, 8'h5A);
      io_read(16'h023B, d, h);
      check("R2 spare byte readback", d, 8'h5A);
      cfg_write(8'h44, 32'h10);
      io_read(16'h0239, d, h);
      check("R10 bad key keeps placement", h, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_in_ignored();
      t_sda();
      t_scl();
      t_wired();
      t_outside();
      t_remap();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule